// File: doc/BRIEF.md
# Flash Write Status Polling Output

This block is the device-side status generator of a parallel NOR-style flash with a byte-wide read port. After the final write strobe of a program or erase command is taken, it holds the operation's context: kind, target address, selected and protected sectors, and the value that bit 7 will show when the operation is done. While the internal algorithm runs, a host read at a matching address returns a status byte instead of array data. In that byte, bit 7 is the inverse of the final value of bit 7 and bits 6:0 are zero. Reads at any other address pass the array contents straight through.

The cell array, the command decoder and the internal algorithm timing are outside the block. A single-cycle start strobe stands for the last write pulse. A completion strobe ends a normal operation. An operation aimed only at protected sectors is not completed by the strobe: it ends by itself after a fixed time, counted in clock cycles from a clock-frequency parameter. A ready output is high when the device accepts reads of normal data and low while an operation is busy.

On the first qualifying read after completion, bit 7 already shows its final value while bits 6:0 still read as zero. The full byte becomes array data only on the read after that, which mirrors the way the top data bit settles one read ahead of the others.

Top module: `flash_poll_status`

## Requirements
- R1: After synchronous reset, `ready` is 1, no operation is pending, a read with `rd_en` high returns `array_data` unchanged, and with `rd_en` low `rd_data` is 0.
- R2: While a program to an unprotected sector is busy, `ready` is 0 and a read at exactly the programmed address returns `{~prog_msb, 7'b0}` whatever `array_data` holds.
- R3: While busy, a read at an address outside the polling range returns `array_data` unchanged. For a program, the polling range is the programmed address only.
- R4: While an erase is busy, `ready` is 0 and a read inside the polling range returns 8'h00. For sector erase the range is every sector set in `sel_mask`. For chip erase it is every sector clear in `prot_mask`. The sector number is the top `log2(NSEC)` address bits.
- R5: While an erase is busy and `suspend` is high, `ready` is 1 and a read inside the polling range returns 8'h80. Dropping `suspend` restores the busy status.
- R6: When the completion strobe ends a program or erase, `ready` returns to 1. The first later read inside the polling range returns the final bit 7 (`prog_msb` for program, 1 for erase) with bits 6:0 zero. Reads after that one return `array_data`. A read in the same cycle as the strobe still shows busy status.
- R7: A program whose target sector is set in `prot_mask` holds `ready` low for exactly `PGM_PROT_US*CLK_MHZ` cycles, showing busy status at the target address. It then returns to array reads without the one-read bit-7 step.
- R8: A sector erase whose selected sectors are all protected, or a chip erase with every sector protected, holds `ready` low for exactly `ERS_PROT_US*CLK_MHZ` cycles. An erase with at least one unprotected selected sector stays busy until the completion strobe, however long that takes.
- R9: A start strobe while an operation is busy or timing out is ignored, and so is a completion strobe during a protected-target window or while idle.
- R10: `op_kind` is sampled on `op_start`: 2'b00 program, 2'b01 sector erase, 2'b10 chip erase. The code 2'b11 starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_start | input | 1 | One-cycle strobe marking the final write pulse of a command |
| op_kind | input | 2 | Operation code sampled with `op_start` |
| op_addr | input | AW | Program address sampled with `op_start` |
| prog_msb | input | 1 | Bit 7 of the datum being programmed |
| sel_mask | input | NSEC | Sectors chosen for a sector erase |
| prot_mask | input | NSEC | Protected sectors, sampled with `op_start` |
| suspend | input | 1 | Erase-suspend flag |
| op_done | input | 1 | Completion strobe from the internal algorithm |
| rd_en | input | 1 | Output enable of the host read port |
| rd_addr | input | AW | Host read address |
| array_data | input | DW | Array contents at `rd_addr` |
| rd_data | output | DW | Read data: status byte or array data |
| ready | output | 1 | High when idle or erase-suspended, low while busy |

## Verification
Two events can fall in the same clock: the completion strobe and a host read inside the polling range. The bench raises `op_done` in the same cycle as such a read. It expects busy status on that read, the one-read bit-7 step on the next qualifying read, and plain array data on the one after. Completion is also raised during a protected-target window, and the bench checks that the window still lasts its full cycle count.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

    typedef enum logic [1:0] {
        OP_PGM  = 2'b00,
        OP_SER  = 2'b01,
        OP_CHP  = 2'b10,
        OP_NONE = 2'b11
    } op_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_PGM  = 2'b01,
        ST_ERS  = 2'b10,
        ST_PROT = 2'b11
    } poll_st_e;

    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // microseconds to cycles, never below one cycle
    function automatic int us_cycles(input int mhz, input int us);
        return (mhz * us < 1) ? 1 : mhz * us;
    endfunction

    // width of a down-counter that starts at lim-1
    function automatic int cnt_bits(input int lim);
        return (lim < 3) ? 1 : $clog2(lim);
    endfunction

endpackage

// File: rtl/poll_ctrl.sv
module poll_ctrl
    import flash_poll_pkg::*;
#(
    parameter int AW      = 19,
    parameter int NSEC    = 8,
    parameter int PGM_LIM = 100,
    parameter int ERS_LIM = 5000,
    parameter int CW      = 13
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            op_start,
    input  logic [1:0]      op_kind,
    input  logic [AW-1:0]   op_addr,
    input  logic            prog_msb,
    input  logic [NSEC-1:0] sel_mask,
    input  logic [NSEC-1:0] prot_mask,
    input  logic            op_done,
    input  logic            suspend,
    input  logic            lag_take,
    output poll_st_e        st,
    output logic [CW-1:0]   cnt,
    output logic [AW-1:0]   ctx_addr,
    output logic [NSEC-1:0] ctx_vmask,
    output logic            ctx_prog,
    output logic            ctx_true7,
    output logic            lag,
    output logic            ready
);
    localparam int SW = $clog2(NSEC);

    logic [SW-1:0]   op_sec;
    logic [NSEC-1:0] ser_eff;
    logic [NSEC-1:0] chp_eff;
    logic            go;
    poll_st_e        nxt;
    logic [CW-1:0]   lim_ld;
    logic [NSEC-1:0] vm_ld;
    logic            prog_ld;
    logic            t7_ld;

    assign op_sec  = op_addr[AW-1 -: SW];
    assign ser_eff = sel_mask & ~prot_mask;
    assign chp_eff = ~prot_mask;

    // decode of the command being launched
    always_comb begin
        go      = 1'b0;
        nxt     = ST_IDLE;
        lim_ld  = '0;
        vm_ld   = '0;
        prog_ld = 1'b0;
        t7_ld   = 1'b1;
        case (op_kind_e'(op_kind))
            OP_PGM: begin
                go      = 1'b1;
                prog_ld = 1'b1;
                t7_ld   = prog_msb;
                if (prot_mask[op_sec]) begin
                    nxt    = ST_PROT;
                    lim_ld = CW'(PGM_LIM - 1);
                end else begin
                    nxt = ST_PGM;
                end
            end
            OP_SER: begin
                go    = 1'b1;
                vm_ld = sel_mask;
                if (ser_eff == '0) begin
                    nxt    = ST_PROT;
                    lim_ld = CW'(ERS_LIM - 1);
                end else begin
                    nxt = ST_ERS;
                end
            end
            OP_CHP: begin
                go = 1'b1;
                if (chp_eff == '0) begin
                    nxt    = ST_PROT;
                    lim_ld = CW'(ERS_LIM - 1);
                    vm_ld  = '1;
                end else begin
                    nxt   = ST_ERS;
                    vm_ld = chp_eff;
                end
            end
            default: go = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            ctx_addr  <= '0;
            ctx_vmask <= '0;
            ctx_prog  <= 1'b0;
            ctx_true7 <= 1'b0;
            lag       <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (op_start && go) begin
                        st        <= nxt;
                        cnt       <= lim_ld;
                        ctx_addr  <= op_addr;
                        ctx_vmask <= vm_ld;
                        ctx_prog  <= prog_ld;
                        ctx_true7 <= t7_ld;
                        lag       <= 1'b0;
                    end else if (lag_take) begin
                        lag <= 1'b0;
                    end
                end
                ST_PGM, ST_ERS: begin
                    if (op_done) begin
                        st  <= ST_IDLE;
                        lag <= 1'b1;
                    end
                end
                ST_PROT: begin
                    if (cnt == '0) st <= ST_IDLE;
                    else           cnt <= cnt - 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign ready = (st == ST_IDLE) || ((st == ST_ERS) && suspend);

endmodule

// File: rtl/poll_addr_match.sv
module poll_addr_match #(
    parameter int AW   = 19,
    parameter int NSEC = 8
) (
    input  logic [AW-1:0]   rd_addr,
    input  logic [AW-1:0]   ctx_addr,
    input  logic [NSEC-1:0] ctx_vmask,
    input  logic            ctx_prog,
    output logic            hit
);
    localparam int SW = $clog2(NSEC);

    logic [SW-1:0] rd_sec;
    assign rd_sec = rd_addr[AW-1 -: SW];

    // program polls one address, erase polls whole sectors
    assign hit = ctx_prog ? (rd_addr == ctx_addr) : ctx_vmask[rd_sec];

endmodule

// File: rtl/poll_read_mux.sv
module poll_read_mux
    import flash_poll_pkg::*;
#(
    parameter int DW = 8
) (
    input  poll_st_e        st,
    input  logic            suspend,
    input  logic            lag,
    input  logic            hit,
    input  logic            rd_en,
    input  logic            ctx_true7,
    input  logic [DW-1:0]   array_data,
    output logic [DW-1:0]   rd_data,
    output logic            lag_take
);
    logic busy_stat;
    logic final_stat;

    assign busy_stat  = (st == ST_PGM) || (st == ST_PROT) ||
                        ((st == ST_ERS) && !suspend);
    assign final_stat = ((st == ST_ERS) && suspend) ||
                        ((st == ST_IDLE) && lag);

    always_comb begin
        if (!rd_en)
            rd_data = '0;
        else if (hit && busy_stat)
            rd_data = {~ctx_true7, {(DW-1){1'b0}}};
        else if (hit && final_stat)
            rd_data = {ctx_true7, {(DW-1){1'b0}}};
        else
            rd_data = array_data;
    end

    assign lag_take = rd_en && hit && lag && (st == ST_IDLE);

endmodule

// File: rtl/flash_poll_status.sv
module flash_poll_status
    import flash_poll_pkg::*;
#(
    parameter int AW          = 19,
    parameter int DW          = 8,
    parameter int NSEC        = 8,
    parameter int CLK_MHZ     = 50,
    parameter int PGM_PROT_US = 2,
    parameter int ERS_PROT_US = 100
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            op_start,
    input  logic [1:0]      op_kind,
    input  logic [AW-1:0]   op_addr,
    input  logic            prog_msb,
    input  logic [NSEC-1:0] sel_mask,
    input  logic [NSEC-1:0] prot_mask,
    input  logic            suspend,
    input  logic            op_done,
    input  logic            rd_en,
    input  logic [AW-1:0]   rd_addr,
    input  logic [DW-1:0]   array_data,
    output logic [DW-1:0]   rd_data,
    output logic            ready
);
    localparam int PGM_LIM = us_cycles(CLK_MHZ, PGM_PROT_US);
    localparam int ERS_LIM = us_cycles(CLK_MHZ, ERS_PROT_US);
    localparam int CW      = cnt_bits(max_i(PGM_LIM, ERS_LIM));

    poll_st_e        st;
    logic [CW-1:0]   cnt;
    logic [AW-1:0]   ctx_addr;
    logic [NSEC-1:0] ctx_vmask;
    logic            ctx_prog;
    logic            true7;
    logic            lag;
    logic            hit;
    logic            lag_take;

    poll_ctrl #(
        .AW(AW), .NSEC(NSEC), .PGM_LIM(PGM_LIM), .ERS_LIM(ERS_LIM), .CW(CW)
    ) u_ctrl (
        .clk(clk), .rst(rst),
        .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr),
        .prog_msb(prog_msb), .sel_mask(sel_mask), .prot_mask(prot_mask),
        .op_done(op_done), .suspend(suspend), .lag_take(lag_take),
        .st(st), .cnt(cnt), .ctx_addr(ctx_addr), .ctx_vmask(ctx_vmask),
        .ctx_prog(ctx_prog), .ctx_true7(true7), .lag(lag), .ready(ready)
    );

    poll_addr_match #(.AW(AW), .NSEC(NSEC)) u_match (
        .rd_addr(rd_addr), .ctx_addr(ctx_addr), .ctx_vmask(ctx_vmask),
        .ctx_prog(ctx_prog), .hit(hit)
    );

    poll_read_mux #(.DW(DW)) u_mux (
        .st(st), .suspend(suspend), .lag(lag), .hit(hit), .rd_en(rd_en),
        .ctx_true7(true7), .array_data(array_data),
        .rd_data(rd_data), .lag_take(lag_take)
    );

endmodule

// File: rtl/flash_poll_chk.sv
module flash_poll_chk
    import flash_poll_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 13
) (
    input logic          clk,
    input logic          rst,
    input logic          op_start,
    input logic [1:0]    op_kind,
    input logic          op_done,
    input logic          suspend,
    input logic          rd_en,
    input logic [DW-1:0] rd_data,
    input logic [DW-1:0] array_data,
    input logic          ready,
    input poll_st_e      st,
    input logic [CW-1:0] cnt,
    input logic          hit,
    input logic          lag,
    input logic          true7
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (ready && !lag));

    assert_pgm_status_R2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PGM && rd_en && hit) |-> (rd_data[DW-1] == ~true7 && !ready));

    assert_miss_passes_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !hit) |-> (rd_data == array_data));

    assert_erase_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ERS && !suspend && rd_en && hit) |-> (rd_data[DW-1] == 1'b0));

    assert_suspend_one_R5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ERS && suspend) |-> (ready && (!(rd_en && hit) || rd_data[DW-1])));

    assert_done_lag_R6: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_PGM || st == ST_ERS) && op_done) |=> (st == ST_IDLE && lag && ready));

    assert_window_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PROT) |-> !ready);

    assert_window_count_R8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PROT && cnt != '0) |=> (st == ST_PROT && cnt == $past(cnt) - 1'b1));

    assert_busy_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PGM && !op_done) |=> (st == ST_PGM && $stable(true7)));

    assert_bad_kind_R10: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && op_start && op_kind == 2'b11) |=> (st == ST_IDLE));

endmodule

bind flash_poll_status flash_poll_chk #(.DW(DW), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .op_start(op_start), .op_kind(op_kind),
    .op_done(op_done), .suspend(suspend), .rd_en(rd_en), .rd_data(rd_data),
    .array_data(array_data), .ready(ready), .st(st), .cnt(cnt), .hit(hit),
    .lag(lag), .true7(true7)
);

// File: tb/sim_flash_poll_status.sv
module sim_flash_poll_status;

    localparam int AW = 19;
    localparam int DW = 8;
    localparam int NSEC = 8;
    localparam int PGM_WIN = 100;
    localparam int ERS_WIN = 5000;

    typedef struct packed {
        logic [AW-1:0] a;
        logic [DW-1:0] arr;
        logic [DW-1:0] exp;
        logic          is_r2;
    } vec_t;

    // reads during a program of 8'h5A at 19'h21234 (busy status = 8'h80)
    localparam vec_t PGV [6] = '{
        '{19'h21234, 8'h33, 8'h80, 1'b1},
        '{19'h21235, 8'h33, 8'h33, 1'b0},
        '{19'h01234, 8'hC1, 8'hC1, 1'b0},
        '{19'h21234, 8'hFF, 8'h80, 1'b1},
        '{19'h61234, 8'h00, 8'h00, 1'b0},
        '{19'h21234, 8'h7E, 8'h80, 1'b1}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            op_start = 1'b0;
    logic [1:0]      op_kind = 2'b00;
    logic [AW-1:0]   op_addr = '0;
    logic            prog_msb = 1'b0;
    logic [NSEC-1:0] sel_mask = '0;
    logic [NSEC-1:0] prot_mask = '0;
    logic            suspend = 1'b0;
    logic            op_done = 1'b0;
    logic            rd_en = 1'b0;
    logic [AW-1:0]   rd_addr = '0;
    logic [DW-1:0]   array_data = '0;
    logic [DW-1:0]   rd_data;
    logic            ready;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    flash_poll_status #(.AW(AW), .DW(DW), .NSEC(NSEC)) u0 (
        .clk(clk), .rst(rst), .op_start(op_start), .op_kind(op_kind),
        .op_addr(op_addr), .prog_msb(prog_msb), .sel_mask(sel_mask),
        .prot_mask(prot_mask), .suspend(suspend), .op_done(op_done),
        .rd_en(rd_en), .rd_addr(rd_addr), .array_data(array_data),
        .rd_data(rd_data), .ready(ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] arr,
                      input logic [DW-1:0] exp, input string req);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a; array_data = arr;
        #5;
        chk(req, 32'(rd_data), 32'(exp));
    endtask

    task automatic quiet();
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic start_op(input logic [1:0] k, input logic [AW-1:0] a, input logic m,
                            input logic [NSEC-1:0] sel, input logic [NSEC-1:0] prot);
        @(negedge clk);
        op_start = 1'b1; op_kind = k; op_addr = a; prog_msb = m;
        sel_mask = sel; prot_mask = prot; rd_en = 1'b0;
        @(negedge clk);
        op_start = 1'b0;
    endtask

    task automatic finish_op();
        @(negedge clk);
        op_done = 1'b1; rd_en = 1'b0;
        @(negedge clk);
        op_done = 1'b0;
    endtask

    // counts cycles with ready low, pulsing op_done on the first one
    task automatic count_window(output int n);
        n = 0;
        while (!ready && n < ERS_WIN + 20) begin
            n++;
            op_done = (n == 1);
            #5;
            @(negedge clk);
        end
        op_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        // R1: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #5 chk("R1 ready", 32'(ready), 32'd1);
        rd(19'h12345, 8'hA5, 8'hA5, "R1 read");
        quiet();
        #5 chk("R1 rd_en low", 32'(rd_data), 32'd0);

        // R10: code 2'b11 starts nothing
        start_op(2'b11, 19'h21234, 1'b0, 8'hFF, 8'h00);
        #5 chk("R10 ready", 32'(ready), 32'd1);
        rd(19'h21234, 8'h5C, 8'h5C, "R10 read");

        // R2 / R3: program table
        start_op(2'b00, 19'h21234, 1'b0, 8'h00, 8'h00);
        #5 chk("R2 ready low", 32'(ready), 32'd0);
        for (int i = 0; i < 6; i++)
            rd(PGV[i].a, PGV[i].arr, PGV[i].exp, PGV[i].is_r2 ? "R2 table" : "R3 table");

        // R9: second start ignored while busy
        start_op(2'b00, 19'h31111, 1'b1, 8'h00, 8'h00);
        rd(19'h21234, 8'h44, 8'h80, "R9 status kept");
        rd(19'h31111, 8'h44, 8'h44, "R9 new addr ignored");

        // R6: completion in the same cycle as a qualifying read
        @(negedge clk);
        op_done = 1'b1; rd_en = 1'b1; rd_addr = 19'h21234; array_data = 8'h11;
        #5 chk("R6 same cycle busy", 32'(rd_data), 32'h80);
        @(negedge clk);
        op_done = 1'b0; rd_en = 1'b0;
        #5 chk("R6 ready", 32'(ready), 32'd1);
        rd(19'h21234, 8'h11, 8'h00, "R6 lag read");
        rd(19'h21234, 8'h11, 8'h11, "R6 array after");

        // R2 / R6 with a set top bit, miss read leaves the lag pending
        start_op(2'b00, 19'h70000, 1'b1, 8'h00, 8'h00);
        rd(19'h70000, 8'h3C, 8'h00, "R2 msb set");
        finish_op();
        rd(19'h10000, 8'h3C, 8'h3C, "R3 miss after done");
        rd(19'h70000, 8'h3C, 8'h80, "R6 lag msb");
        rd(19'h70000, 8'h3C, 8'h3C, "R6 array msb");
        quiet();

        // R4 / R5 / R8: sector erase, sectors 2 and 4 selected, 2 protected
        start_op(2'b01, 19'h0, 1'b0, 8'h14, 8'h04);
        #5 chk("R4 ready low", 32'(ready), 32'd0);
        rd(19'h20010, 8'hFF, 8'h00, "R4 protected selected sector");
        rd(19'h40010, 8'hFF, 8'h00, "R4 selected sector");
        rd(19'h10010, 8'h5A, 8'h5A, "R4 unselected sector");
        quiet();
        suspend = 1'b1;
        #5 chk("R5 ready", 32'(ready), 32'd1);
        rd(19'h40010, 8'h12, 8'h80, "R5 suspend status");
        @(negedge clk);
        suspend = 1'b0;
        rd(19'h40010, 8'h12, 8'h00, "R5 resume");
        quiet();
        repeat (ERS_WIN + 5) @(negedge clk);
        chk("R8 partial stays busy", 32'(ready), 32'd0);
        finish_op();
        rd(19'h40010, 8'h6D, 8'h80, "R6 erase lag");
        rd(19'h40010, 8'h6D, 8'h6D, "R6 erase array");
        quiet();

        // R4: chip erase, sectors 0 and 1 protected
        start_op(2'b10, 19'h0, 1'b0, 8'h00, 8'h03);
        rd(19'h00100, 8'h77, 8'h77, "R4 chip protected passes");
        rd(19'h50100, 8'h77, 8'h00, "R4 chip unprotected");
        finish_op();
        rd(19'h50100, 8'h77, 8'h80, "R6 chip lag");
        quiet();

        // R7: program into protected sector, op_done inside window (R9)
        start_op(2'b00, 19'h20044, 1'b0, 8'h00, 8'h04);
        rd_en = 1'b1; rd_addr = 19'h20044; array_data = 8'h01;
        #5 chk("R7 window status", 32'(rd_data), 32'h80);
        rd_en = 1'b0;
        count_window(n);
        chk("R7 R9 window length", 32'(n), 32'(PGM_WIN));
        rd(19'h20044, 8'h01, 8'h01, "R7 array after window");
        quiet();

        // R8: all-protected sector erase and chip erase
        start_op(2'b01, 19'h0, 1'b0, 8'h0C, 8'h0C);
        count_window(n);
        chk("R8 sector window", 32'(n), 32'(ERS_WIN));
        start_op(2'b10, 19'h0, 1'b0, 8'h00, 8'hFF);
        count_window(n);
        chk("R8 chip window", 32'(n), 32'(ERS_WIN));
        rd(19'h30000, 8'h9A, 8'h9A, "R8 array after window");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule